// File: doc/BRIEF.md
# Halfword Load Decode-Execute Unit

This unit takes one fetched instruction at a time and carries out an immediate-offset halfword load. An instruction from the fixed-width set arrives as one 32-bit word. An instruction from the compact set arrives as either one 16-bit halfword or a pair of halfwords. An outside condition evaluator supplies a condition-pass bit with the instruction. The unit recognises four load encodings and maps each one onto a single datapath. That datapath has three modes: plain offset, pre-indexed and post-indexed. For every encoding the unit reads the base register, computes the offset address and chooses the access address.

For a load that is allowed to run, the unit issues one two-byte read on a valid/ready request port and waits for the response strobe. It then retires in a single completion cycle. In that cycle it writes the base register when the mode writes back, and it writes the destination with the returned halfword zero-extended to 32 bits. Some encodings belong to neighbouring instructions: the literal, unprivileged, preload and preload-for-write forms. Other encodings are undefined or unpredictable, and some words do not match any form. For all of these the unit reports a result code, makes no memory access and writes no register.

Top module: `hword_load_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `mem_req_valid`, `done`, `wr_base_en` and `wr_dst_en` are all 0.
- R2: In fixed-width mode (`in_wide`=1) the word must satisfy all of the following: condition field [31:28] is not 1111, [27:25]=000, [22]=1, [20]=1 and [7:4]=1011. The immediate is {[11:8],[3:0]}, the base is [19:16] and the destination is [15:12]. Bit [24] selects pre-application of the offset, bit [23] selects addition, and writeback is on when [24]=0 or [21]=1.
- R3: A single compact halfword (`in_wide`=0, `in_two`=0, placed in `in_word[15:0]`) matches when [15:11]=10001. The base is [5:3] and the destination is [2:0]. The offset is [10:6] shifted left by one. The offset is always added and applied before the access, with no writeback.
- R4: A compact pair (`in_two`=1) carries the first halfword in `in_word[31:16]` and the second in `in_word[15:0]`. If the first halfword is 1111_1000_1011 followed by the base, the destination is second[15:12]. The offset is second[11:0], always added and applied before the access, with no writeback.
- R5: If the first halfword is 1111_1000_0011 followed by the base and second[11]=1, the destination is second[15:12] and the offset is second[7:0]. Pre-application is second[10], addition is second[9] and writeback is second[8].
- R6: The offset address is the base plus the offset when addition is selected, and the base minus the offset otherwise. The memory address is the offset address when pre-applied, and the unchanged base otherwise. Exactly one read request is made per executed load.
- R7: When an executed load completes, `done` is high for one cycle. In that cycle the destination is written with {16'b0, halfword}, and, only for writeback forms, the base is written with the offset address.
- R8: `done_code` values are: 0 executed or condition-failed, 1 literal form, 2 unprivileged form, 3 preload, 4 preload-for-write, 5 undefined, 6 unpredictable, 7 no match. A base field of 1111 gives code 1 in every form that has a 4-bit base field. The exception is the R4 form, where a destination of 1111 gives code 3 first. A non-matching word gives code 7.
- R9: Code 2 is reported for the R2 form with [24]=0 and [21]=1, and for the R5 form with P,U,W=110. Code 4 is reported for the R5 form with destination 1111 and P,U,W=100.
- R10: Code 5 is reported for the R5 form with P=0 and W=0, and for any writeback form whose base equals its destination.
- R11: Code 6 is reported for the R2 form with destination 1111, and for the R5 form with destination 1111 and W=1.
- R12: Any nonzero code, and any instruction with `in_cond_pass`=0, completes with no memory request and no register write.
- R13: `in_ready` is high only while no instruction is in progress. A pending read request holds its address until it is accepted.
- R14: `done` rises exactly one cycle after the response strobe. A load's latency therefore depends on memory timing only, never on the data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and accepting |
| in_wide | input | 1 | 1 = fixed-width word, 0 = compact set |
| in_two | input | 1 | Compact instruction is a halfword pair |
| in_word | input | 32 | Instruction bits |
| in_cond_pass | input | 1 | Condition check passed |
| rf_raddr | output | 4 | Base register read index |
| rf_rdata | input | 32 | Base register value (same cycle) |
| mem_req_valid | output | 1 | Halfword read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_addr | output | 32 | Byte address of the halfword |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 16 | Returned halfword |
| done | output | 1 | Completion pulse |
| done_code | output | 3 | Result code (R8) |
| wr_base_en | output | 1 | Base writeback enable |
| wr_base_addr | output | 4 | Base register index |
| wr_base_data | output | 32 | Offset address written back |
| wr_dst_en | output | 1 | Destination write enable |
| wr_dst_addr | output | 4 | Destination register index |
| wr_dst_data | output | 32 | Zero-extended halfword |

## Verification
The assertions assume a well-behaved environment in three respects. First, memory sends exactly one response strobe per accepted request, and only after that request has been accepted. Second, the register value is present in the same cycle the index is driven. Third, the offered instruction stays stable while `in_valid` is high. The bench's memory model meets these assumptions by construction. It answers one cycle after each handshake, and it can hold `mem_req_ready` low for a few cycles to exercise the stall path. The bench's register model is a combinational function of the index. Instructions are offered only while the unit is idle and are withdrawn right after acceptance.

// File: rtl/hword_load_unit.sv
module hword_load_unit #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_wide,
  input  logic          in_two,
  input  logic [31:0]   in_word,
  input  logic          in_cond_pass,
  output logic [3:0]    rf_raddr,
  input  logic [XW-1:0] rf_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [XW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [15:0]   mem_rsp_data,
  output logic          done,
  output logic [2:0]    done_code,
  output logic          wr_base_en,
  output logic [3:0]    wr_base_addr,
  output logic [XW-1:0] wr_base_data,
  output logic          wr_dst_en,
  output logic [3:0]    wr_dst_addr,
  output logic [XW-1:0] wr_dst_data
);
  localparam logic [2:0] K_OK = 3'd0, K_LIT = 3'd1, K_UNPRIV = 3'd2, K_PLD = 3'd3,
                         K_PLDW = 3'd4, K_UNDEF = 3'd5, K_UNPRED = 3'd6, K_NOMATCH = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t st;
  logic [2:0]  d_kind;
  logic [3:0]  d_rn, d_rt;
  logic [11:0] d_imm;
  logic        d_idx, d_add, d_wb;
  logic [15:0] hi, lo;

  assign hi = in_word[31:16];
  assign lo = in_word[15:0];

  always_comb begin
    d_kind = K_NOMATCH;
    d_rn   = 4'd0;
    d_rt   = 4'd0;
    d_imm  = 12'd0;
    d_idx  = 1'b1;
    d_add  = 1'b1;
    d_wb   = 1'b0;
    if (in_wide) begin
      d_rn  = in_word[19:16];
      d_rt  = in_word[15:12];
      d_imm = {4'd0, in_word[11:8], in_word[3:0]};
      d_idx = in_word[24];
      d_add = in_word[23];
      d_wb  = !in_word[24] || in_word[21];
      if (in_word[31:28] == 4'hF || in_word[27:25] != 3'b000 || !in_word[22] ||
          !in_word[20] || in_word[7:4] != 4'b1011)
        d_kind = K_NOMATCH;
      else if (d_rn == 4'hF)               d_kind = K_LIT;
      else if (!in_word[24] && in_word[21]) d_kind = K_UNPRIV;
      else if (d_rt == 4'hF)               d_kind = K_UNPRED;
      else if (d_wb && d_rn == d_rt)       d_kind = K_UNDEF;
      else                                 d_kind = K_OK;
    end else if (!in_two) begin
      d_rn  = {1'b0, lo[5:3]};
      d_rt  = {1'b0, lo[2:0]};
      d_imm = {6'd0, lo[10:6], 1'b0};
      d_kind = (lo[15:11] == 5'b10001) ? K_OK : K_NOMATCH;
    end else if (hi[15:4] == 12'hF8B) begin
      d_rn  = hi[3:0];
      d_rt  = lo[15:12];
      d_imm = lo[11:0];
      if (d_rt == 4'hF)      d_kind = K_PLD;
      else if (d_rn == 4'hF) d_kind = K_LIT;
      else                   d_kind = K_OK;
    end else if (hi[15:4] == 12'hF83 && lo[11]) begin
      d_rn  = hi[3:0];
      d_rt  = lo[15:12];
      d_imm = {4'd0, lo[7:0]};
      d_idx = lo[10];
      d_add = lo[9];
      d_wb  = lo[8];
      if (d_rn == 4'hF)                             d_kind = K_LIT;
      else if (d_rt == 4'hF && lo[10:8] == 3'b100) d_kind = K_PLDW;
      else if (lo[10:8] == 3'b110)                 d_kind = K_UNPRIV;
      else if (!lo[10] && !lo[8])                  d_kind = K_UNDEF;
      else if (d_rt == 4'hF && lo[8])              d_kind = K_UNPRED;
      else if (d_wb && d_rn == d_rt)               d_kind = K_UNDEF;
      else                                         d_kind = K_OK;
    end
  end

  logic [XW-1:0] imm_x, off_addr, acc_addr;
  assign rf_raddr = d_rn;
  assign imm_x    = {{(XW-12){1'b0}}, d_imm};
  assign off_addr = d_add ? rf_rdata + imm_x : rf_rdata - imm_x;
  assign acc_addr = d_idx ? off_addr : rf_rdata;

  logic [XW-1:0] r_off, r_acc;
  logic [3:0]    r_rn, r_rt;
  logic [2:0]    r_kind;
  logic          r_wb, r_go;
  logic [15:0]   r_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      r_off  <= '0;
      r_acc  <= '0;
      r_rn   <= '0;
      r_rt   <= '0;
      r_kind <= K_OK;
      r_wb   <= 1'b0;
      r_go   <= 1'b0;
      r_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          r_off  <= off_addr;
          r_acc  <= acc_addr;
          r_rn   <= d_rn;
          r_rt   <= d_rt;
          r_kind <= d_kind;
          r_wb   <= d_wb;
          r_go   <= (d_kind == K_OK) && in_cond_pass;
          st     <= ((d_kind == K_OK) && in_cond_pass) ? S_REQ : S_DONE;
        end
        S_REQ:  if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          r_data <= mem_rsp_data;
          st     <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready      = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_addr      = r_acc;
  assign done          = (st == S_DONE);
  assign done_code     = r_kind;
  assign wr_base_en    = done && r_go && r_wb;
  assign wr_base_addr  = r_rn;
  assign wr_base_data  = r_off;
  assign wr_dst_en     = done && r_go;
  assign wr_dst_addr   = r_rt;
  assign wr_dst_data   = {{(XW-16){1'b0}}, r_data};
endmodule

// File: rtl/hword_load_unit_chk.sv
module hword_load_unit_chk #(
  parameter int XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [XW-1:0] mem_addr,
  input logic          mem_rsp_valid,
  input logic          done,
  input logic [2:0]    done_code,
  input logic          wr_base_en,
  input logic [3:0]    wr_base_addr,
  input logic          wr_dst_en,
  input logic [3:0]    wr_dst_addr
);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req_valid && !done);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  p_write_in_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base_en || wr_dst_en) |-> done);

  p_base_implies_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_en |-> wr_dst_en);

  p_flag_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_code != 3'd0 |-> !wr_dst_en && !wr_base_en);

  p_no_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_en |-> wr_base_addr != wr_dst_addr);

  p_rsp_then_done_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !in_ready && !mem_req_valid && !done |=> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);
endmodule

bind hword_load_unit hword_load_unit_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
  .done(done), .done_code(done_code), .wr_base_en(wr_base_en),
  .wr_base_addr(wr_base_addr), .wr_dst_en(wr_dst_en), .wr_dst_addr(wr_dst_addr)
);

// File: tb/sim_hword_load_unit.sv
module sim_hword_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_wide = 1'b0, in_two = 1'b0, in_cond_pass = 1'b1;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        done, wr_base_en, wr_dst_en;
  logic [2:0]  done_code;
  logic [3:0]  wr_base_addr, wr_dst_addr;
  logic [31:0] wr_base_data, wr_dst_data;

  int checks = 0, errors = 0;
  int nreq = 0, wcnt = 0;
  logic stall_en = 1'b0;
  logic [31:0] last_addr = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rfv(input logic [3:0] a);
    return 32'h1000_0000 | ({28'd0, a} << 8);
  endfunction
  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[16:1] ^ 16'hC3A5;
  endfunction

  assign rf_rdata = rfv(rf_raddr);
  assign mem_req_ready = !stall_en || wcnt >= 3;

  always @(posedge clk) begin
    wcnt <= mem_req_valid ? wcnt + 1 : 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= memf(mem_addr);
      last_addr     <= mem_addr;
      nreq          <= nreq + 1;
    end
  end

  hword_load_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_two(in_two), .in_word(in_word), .in_cond_pass(in_cond_pass),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_code(done_code),
    .wr_base_en(wr_base_en), .wr_base_addr(wr_base_addr), .wr_base_data(wr_base_data),
    .wr_dst_en(wr_dst_en), .wr_dst_addr(wr_dst_addr), .wr_dst_data(wr_dst_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [2:0]  o_code;
  logic        o_be, o_de;
  logic [3:0]  o_ba, o_da;
  logic [31:0] o_bd, o_dd, o_addr;
  int          o_req, o_lat;

  task automatic run(input logic wide, input logic two, input logic [31:0] w, input logic cp);
    int n0;
    @(negedge clk);
    n0 = nreq;
    in_wide = wide; in_two = two; in_word = w; in_cond_pass = cp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    o_lat = 0;
    while (!done && o_lat < 40) begin
      o_lat++;
      @(negedge clk);
    end
    if (!done) begin
      errors++;
      $display("FAIL R14 completion missing actual=0 expected=1");
    end
    o_code = done_code; o_be = wr_base_en; o_de = wr_dst_en;
    o_ba = wr_base_addr; o_da = wr_dst_addr; o_bd = wr_base_data; o_dd = wr_dst_data;
    o_req = nreq - n0; o_addr = last_addr;
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, in_ready}, 32'd1);
    chk("R1 req", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 writes", {30'd0, wr_base_en, wr_dst_en}, 32'd0);
  endtask

  task automatic t_load(input string tag, input logic wide, input logic two, input logic [31:0] w,
                        input logic [3:0] rn, input logic [3:0] rt, input logic [31:0] ea,
                        input logic wb, input logic [31:0] wbv);
    run(wide, two, w, 1'b1);
    chk({tag, " code"}, {29'd0, o_code}, 32'd0);
    chk({"R6 ", tag, " one request"}, o_req, 32'd1);
    chk({"R6 ", tag, " address"}, o_addr, ea);
    chk({"R7 ", tag, " dst en"}, {31'd0, o_de}, 32'd1);
    chk({"R7 ", tag, " dst idx"}, {28'd0, o_da}, {28'd0, rt});
    chk({"R7 ", tag, " zero-ext data"}, o_dd, {16'd0, memf(ea)});
    chk({"R7 ", tag, " base en"}, {31'd0, o_be}, {31'd0, wb});
    if (wb) begin
      chk({"R7 ", tag, " base idx"}, {28'd0, o_ba}, {28'd0, rn});
      chk({"R7 ", tag, " base value"}, o_bd, wbv);
    end
    chk({"R14 ", tag, " latency"}, o_lat, stall_en ? 32'd5 : 32'd2);
  endtask

  task automatic t_flag(input string tag, input logic wide, input logic two, input logic [31:0] w,
                        input logic [2:0] code);
    run(wide, two, w, 1'b1);
    chk({tag, " code"}, {29'd0, o_code}, {29'd0, code});
    chk({"R12 ", tag, " no request"}, o_req, 32'd0);
    chk({"R12 ", tag, " no writes"}, {30'd0, o_be, o_de}, 32'd0);
  endtask

  task automatic t_cond_fail;
    run(1'b1, 1'b0, 32'hE1D234BC, 1'b0);
    chk("R12 cond-fail code", {29'd0, o_code}, 32'd0);
    chk("R12 cond-fail no request", o_req, 32'd0);
    chk("R12 cond-fail no writes", {30'd0, o_be, o_de}, 32'd0);
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    t_load("R13 stalled T2", 1'b0, 1'b1, 32'hF8B1_9FFF, 4'd1, 4'd9, rfv(4'd1) + 32'hFFF, 1'b0, 32'd0);
    stall_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load("R2 fixed offset add", 1'b1, 1'b0, 32'hE1D234BC, 4'd2, 4'd3, rfv(4'd2) + 32'h4C, 1'b0, 32'd0);
    t_load("R2 fixed post sub", 1'b1, 1'b0, 32'hE05451B0, 4'd4, 4'd5, rfv(4'd4), 1'b1, rfv(4'd4) - 32'h10);
    t_load("R2 fixed pre add", 1'b1, 1'b0, 32'hE1F67FBF, 4'd6, 4'd7, rfv(4'd6) + 32'hFF, 1'b1, rfv(4'd6) + 32'hFF);
    t_load("R3 short max offset", 1'b0, 1'b0, 32'h0000_8FE9, 4'd5, 4'd1, rfv(4'd5) + 32'd62, 1'b0, 32'd0);
    t_load("R4 long12", 1'b0, 1'b1, 32'hF8B1_9FFF, 4'd1, 4'd9, rfv(4'd1) + 32'hFFF, 1'b0, 32'd0);
    t_load("R5 neg offset", 1'b0, 1'b1, 32'hF832_4C80, 4'd2, 4'd4, rfv(4'd2) - 32'h80, 1'b0, 32'd0);
    t_load("R5 post add", 1'b0, 1'b1, 32'hF833_8B20, 4'd3, 4'd8, rfv(4'd3), 1'b1, rfv(4'd3) + 32'h20);
    t_stall();
    t_cond_fail();
    t_flag("R8 fixed literal", 1'b1, 1'b0, 32'hE1DF34BC, 3'd1);
    t_flag("R8 long12 literal", 1'b0, 1'b1, 32'hF8BF_2004, 3'd1);
    t_flag("R8 fixed cond 1111", 1'b1, 1'b0, 32'hF1D234BC, 3'd7);
    t_flag("R8 long8 bit11 clear", 1'b0, 1'b1, 32'hF832_4410, 3'd7);
    t_flag("R8 short mismatch", 1'b0, 1'b0, 32'h0000_0000, 3'd7);
    t_flag("R8 long12 preload", 1'b0, 1'b1, 32'hF8B1_F004, 3'd3);
    t_flag("R9 fixed unpriv", 1'b1, 1'b0, 32'hE0F234BC, 3'd2);
    t_flag("R9 long8 unpriv", 1'b0, 1'b1, 32'hF832_4E10, 3'd2);
    t_flag("R9 long8 preload-write", 1'b0, 1'b1, 32'hF832_FC10, 3'd4);
    t_flag("R10 long8 P0W0", 1'b0, 1'b1, 32'hF832_4810, 3'd5);
    t_flag("R10 fixed base==dst wb", 1'b1, 1'b0, 32'hE1F22FBF, 3'd5);
    t_flag("R10 long8 base==dst wb", 1'b0, 1'b1, 32'hF832_2F10, 3'd5);
    t_flag("R11 fixed dst 15", 1'b1, 1'b0, 32'hE1D2F4BC, 3'd6);
    t_flag("R11 long8 dst 15 wb", 1'b0, 1'b1, 32'hF832_FF10, 3'd6);
    @(negedge clk);
    chk("R13 idle after run", {31'd0, in_ready}, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule